// File: doc/BRIEF.md
# Banked Shared-Memory Conflict Resolver

This block serves one memory instruction from a group of 16 lanes against an on-block scratch store split into 16 single-port banks of 32-bit words. Every lane brings an enable bit and a word address, and for writes a data word. The bank of a word is the low four bits of its address, so consecutive words sit in consecutive banks. The whole instruction is either a read or a write.

While the instruction is in service the block raises `stall` and spends one cycle per serving round. In each round every bank does one access. That access is for the lowest-numbered waiting lane that targets the bank, and every waiting lane that asks for that same word rides along with it. The number of rounds therefore equals the largest count of distinct words asked of any single bank. A read that all lanes aim at one word is served in one round. For writes that name the same word, the lowest-numbered lane supplies the stored value. When service ends the block pulses `respValid` for one cycle and presents per-lane read data, per-lane valid bits and the round count.

Top module: `smem_bank_resolver`

## Requirements
- R1: A lane reading word address A (8 bits, bank = A[3:0], row = A[7:4]) returns the value most recently written to A.
- R2: When every enabled lane targets a different bank, service takes one round: `cycleCount` is 1 and `stall` is high for exactly one cycle before `respValid`.
- R3: Service takes as many rounds as the largest number of distinct words requested from one bank, for reads and writes alike: stride 2 gives 2, stride 8 gives 8, and 16 distinct words in one bank give 16.
- R4: Lanes asking for the identical word share one bank access in any round. All 16 lanes reading one word complete in one round, and each lane receives that word.
- R5: When several enabled lanes write the same word, the value from the lowest-numbered of those lanes is stored.
- R6: Disabled lanes are ignored. They add no rounds, write nothing, and return `laneValid` low with read data zero.
- R7: `stall` rises the cycle after an accepted request and falls in the cycle `respValid` is high. A `reqValid` pulse seen while `stall` is high is dropped and has no effect on storage.
- R8: `respValid` is a single-cycle pulse, and at that pulse `laneValid` equals the enable mask of the request. After reset `stall`, `respValid`, `laneValid` and `cycleCount` are all zero.
- R9: A request with no enabled lane completes in one round with `cycleCount` 1 and all `laneValid` bits low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when `stall` is low |
| reqWrite | input | 1 | 1 = write instruction, 0 = read instruction |
| laneActive | input | 16 | Per-lane enable |
| laneAddr | input | 128 | Per-lane word address, lane n at bits [8n+7:8n] |
| laneWdata | input | 512 | Per-lane write data, lane n at bits [32n+31:32n] |
| stall | output | 1 | High while the request is in service |
| respValid | output | 1 | One-cycle pulse when service ends |
| laneValid | output | 16 | Per-lane served flag, complete at `respValid` |
| laneRdata | output | 512 | Per-lane read data, same packing as `laneWdata` |
| cycleCount | output | 5 | Serving rounds used by the last request |

## Verification
The bench first fills the store with writes that spread the lanes over all banks. It then reads back with unit stride, stride 2, stride 8 and a single shared word. These four patterns separate a correct bank mapping from a wrong modulo, and a correct round count from one that counts lanes rather than distinct words. Two further patterns check the finer rules. Two groups of lanes each share a word but meet in one bank, which shows that sharing applies to any subset and not only to a full broadcast. A same-word write from scattered lanes exposes the winner rule. Masked lanes, an empty mask, a 16-deep write conflict and a request that arrives during a stall cover the edges of the control flow.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int LANES  = 16;
  localparam int BANKS  = 16;
  localparam int ROWS   = 16;
  localparam int DW     = 32;
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int AW     = BANK_W + ROW_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES + 1);

  // control-to-datapath strobes
  typedef struct packed {
    logic load;       // capture a new request
    logic serve;      // a serving round happens this cycle
    logic writeMode;  // the request in service is a write
  } strobe_t;
endpackage

// File: rtl/smem_bank_picker.sv
module smem_bank_picker
  import smem_pkg::*;
(
  input  logic [LANES-1:0]             pending,
  input  logic [LANES-1:0][AW-1:0]     addrQ,
  output logic [LANES-1:0]             grant,
  output logic [BANKS-1:0]             bankHit,
  output logic [BANKS-1:0][LANE_W-1:0] leadIdx,
  output logic [BANKS-1:0][ROW_W-1:0]  leadRow
);
  logic [BANKS-1:0][AW-1:0] leadAddr;

  // per bank: lowest-numbered waiting lane that maps here
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              hitB;
    logic [LANE_W-1:0] idxB;
    always_comb begin
      hitB = 1'b0;
      idxB = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && (addrQ[l][BANK_W-1:0] == BANK_W'(b))) begin
          hitB = 1'b1;
          idxB = LANE_W'(l);
        end
      end
    end
    assign bankHit[b]  = hitB;
    assign leadIdx[b]  = idxB;
    assign leadAddr[b] = addrQ[idxB];
    assign leadRow[b]  = addrQ[idxB][AW-1:BANK_W];
  end

  // a lane is served when it asks for the same word as its bank's leader
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign grant[l] = pending[l] &&
                      (addrQ[l] == leadAddr[addrQ[l][BANK_W-1:0]]);
  end
endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] laneActive,
  input  logic [LANES-1:0] grant,
  output strobe_t          strb,
  output logic [LANES-1:0] pending,
  output logic             stall,
  output logic             respValid,
  output logic [LANES-1:0] laneValid,
  output logic [CNT_W-1:0] cycleCount
);
  logic             busy;
  logic             writeQ;
  logic [LANES-1:0] leftOver;

  assign strb.load      = reqValid && !busy;
  assign strb.serve     = busy;
  assign strb.writeMode = writeQ;
  assign leftOver       = pending & ~grant;
  assign stall          = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      writeQ     <= 1'b0;
      pending    <= '0;
      respValid  <= 1'b0;
      laneValid  <= '0;
      cycleCount <= '0;
    end else if (strb.load) begin
      busy       <= 1'b1;
      writeQ     <= reqWrite;
      pending    <= laneActive;
      respValid  <= 1'b0;
      laneValid  <= '0;
      cycleCount <= '0;
    end else if (busy) begin
      pending    <= leftOver;
      laneValid  <= laneValid | grant;
      cycleCount <= cycleCount + CNT_W'(1);
      if (leftOver == '0) begin
        busy      <= 1'b0;
        respValid <= 1'b1;
      end
    end else begin
      respValid <= 1'b0;
    end
  end
endmodule

// File: rtl/smem_datapath.sv
module smem_datapath
  import smem_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [LANES*AW-1:0]          laneAddr,
  input  logic [LANES*DW-1:0]          laneWdata,
  input  logic [LANES-1:0]             grant,
  input  logic [BANKS-1:0]             bankHit,
  input  logic [BANKS-1:0][LANE_W-1:0] leadIdx,
  input  logic [BANKS-1:0][ROW_W-1:0]  leadRow,
  output logic [LANES-1:0][AW-1:0]     addrQ,
  output logic [LANES*DW-1:0]          laneRdata
);
  logic [LANES-1:0][DW-1:0] wdataQ;
  logic [LANES-1:0][DW-1:0] rdataQ;
  logic [BANKS-1:0][DW-1:0] rowData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.load) begin
      addrQ  <= laneAddr;
      wdataQ <= laneWdata;
    end
  end

  // one single-port bank per generate instance
  for (genvar b = 0; b < BANKS; b++) begin : g_store
    logic [DW-1:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (strb.serve && strb.writeMode && bankHit[b])
        mem[leadRow[b]] <= wdataQ[leadIdx[b]];
    end
    assign rowData[b] = mem[leadRow[b]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strb.load) begin
      rdataQ <= '0;
    end else if (strb.serve && !strb.writeMode) begin
      for (int l = 0; l < LANES; l++)
        if (grant[l]) rdataQ[l] <= rowData[addrQ[l][BANK_W-1:0]];
    end
  end

  assign laneRdata = rdataQ;
endmodule

// File: rtl/smem_bank_resolver.sv
module smem_bank_resolver
  import smem_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [LANES-1:0]    laneActive,
  input  logic [LANES*AW-1:0] laneAddr,
  input  logic [LANES*DW-1:0] laneWdata,
  output logic                stall,
  output logic                respValid,
  output logic [LANES-1:0]    laneValid,
  output logic [LANES*DW-1:0] laneRdata,
  output logic [CNT_W-1:0]    cycleCount
);
  strobe_t                      strb;
  logic [LANES-1:0]             pending;
  logic [LANES-1:0]             grant;
  logic [BANKS-1:0]             bankHit;
  logic [BANKS-1:0][LANE_W-1:0] leadIdx;
  logic [BANKS-1:0][ROW_W-1:0]  leadRow;
  logic [LANES-1:0][AW-1:0]     addrQ;

  smem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .laneActive(laneActive), .grant(grant), .strb(strb), .pending(pending),
    .stall(stall), .respValid(respValid), .laneValid(laneValid),
    .cycleCount(cycleCount)
  );

  smem_bank_picker u_pick (
    .pending(pending), .addrQ(addrQ), .grant(grant), .bankHit(bankHit),
    .leadIdx(leadIdx), .leadRow(leadRow)
  );

  smem_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .laneAddr(laneAddr),
    .laneWdata(laneWdata), .grant(grant), .bankHit(bankHit),
    .leadIdx(leadIdx), .leadRow(leadRow), .addrQ(addrQ),
    .laneRdata(laneRdata)
  );
endmodule

// File: rtl/smem_checker.sv
module smem_checker
  import smem_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             stall,
  input logic             respValid,
  input logic [LANES-1:0] laneActive,
  input logic [LANES-1:0] laneValid,
  input logic [CNT_W-1:0] cycleCount
);
  logic [LANES-1:0] activeQ;
  logic [CNT_W-1:0] stallCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ  <= '0;
      stallCnt <= '0;
    end else if (reqValid && !stall) begin
      activeQ  <= laneActive;
      stallCnt <= '0;
    end else if (stall) begin
      stallCnt <= stallCnt + CNT_W'(1);
    end
  end

  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R8
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !stall); // R7
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(reqValid)); // R7
  AST_COST_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (cycleCount == stallCnt)); // R2
  AST_COST_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (cycleCount >= CNT_W'(1) && cycleCount <= CNT_W'(LANES))); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ((laneValid & ~activeQ) == '0)); // R6
  AST_ALL_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (laneValid == activeQ)); // R8
endmodule

bind smem_bank_resolver smem_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .stall(stall),
  .respValid(respValid), .laneActive(laneActive), .laneValid(laneValid),
  .cycleCount(cycleCount)
);

// File: tb/smem_bank_resolver_tb.sv
`timescale 1ns/1ps
module smem_bank_resolver_tb;
  import smem_pkg::*;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                reqValid = 1'b0;
  logic                reqWrite = 1'b0;
  logic [LANES-1:0]    laneActive = '0;
  logic [LANES*AW-1:0] laneAddr = '0;
  logic [LANES*DW-1:0] laneWdata = '0;
  logic                stall;
  logic                respValid;
  logic [LANES-1:0]    laneValid;
  logic [LANES*DW-1:0] laneRdata;
  logic [CNT_W-1:0]    cycleCount;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [BANKS*ROWS];
  logic [AW-1:0] bAddr [LANES];
  logic [DW-1:0] bData [LANES];

  always #2.5 clk = ~clk;

  smem_bank_resolver u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .laneActive(laneActive), .laneAddr(laneAddr), .laneWdata(laneWdata),
    .stall(stall), .respValid(respValid), .laneValid(laneValid),
    .laneRdata(laneRdata), .cycleCount(cycleCount)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [LANES-1:0] act);
    reqWrite   = wr;
    laneActive = act;
    for (int l = 0; l < LANES; l++) begin
      laneAddr[l*AW +: AW]  = bAddr[l];
      laneWdata[l*DW +: DW] = bData[l];
    end
  endtask

  // issue one request, wait for respValid, return rounds seen with stall high
  task automatic runReq(input logic wr, input logic [LANES-1:0] act, output int stallSeen);
    int wd;
    @(negedge clk);
    drive(wr, act);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    stallSeen = 0;
    wd = 0;
    while (!respValid && wd < 100) begin
      if (stall) stallSeen++;
      @(negedge clk);
      wd++;
    end
    check(respValid, "R8 respValid seen", respValid, 1);
    if (wr) begin
      for (int l = LANES - 1; l >= 0; l--)
        if (act[l]) model[bAddr[l]] = bData[l];
    end
  endtask

  task automatic checkRead(input logic [LANES-1:0] act, input string req);
    for (int l = 0; l < LANES; l++) begin
      if (act[l]) begin
        check(laneRdata[l*DW +: DW] == model[bAddr[l]], req,
              laneRdata[l*DW +: DW], model[bAddr[l]]);
        check(laneValid[l], "R8 lane valid", laneValid[l], 1);
      end else begin
        check(!laneValid[l], "R6 idle lane valid", laneValid[l], 0);
        check(laneRdata[l*DW +: DW] == '0, "R6 idle lane data", laneRdata[l*DW +: DW], 0);
      end
    end
  endtask

  task automatic checkCost(input int seen, input int exp, input string req);
    check(cycleCount == CNT_W'(exp), req, cycleCount, exp);
    check(seen == exp, {req, " stall length"}, seen, exp);
  endtask

  task automatic t_reset;
    check(!stall && !respValid, "R8 reset handshake", {stall, respValid}, 0);
    check(laneValid == '0, "R8 reset laneValid", laneValid, 0);
    check(cycleCount == '0, "R8 reset cycleCount", cycleCount, 0);
  endtask

  task automatic t_fill;  // R2: every write spans all banks
    int seen;
    for (int r = 0; r < ROWS; r++) begin
      for (int l = 0; l < LANES; l++) begin
        bAddr[l] = AW'(r * BANKS + l);
        bData[l] = 32'h1000_0000 + (r * BANKS + l) * 32'h0001_0003;
      end
      runReq(1'b1, '1, seen);
      checkCost(seen, 1, "R2 fill write cost");
    end
  endtask

  task automatic t_stride(input int base, input int stride, input int exp, input string req);
    int seen;
    for (int l = 0; l < LANES; l++) bAddr[l] = AW'(base + stride * l);
    runReq(1'b0, '1, seen);
    checkCost(seen, exp, req);
    checkRead('1, "R1 read data");
  endtask

  task automatic t_broadcast;  // R4
    int seen;
    for (int l = 0; l < LANES; l++) bAddr[l] = 8'd37;
    runReq(1'b0, '1, seen);
    checkCost(seen, 1, "R4 broadcast cost");
    checkRead('1, "R4 broadcast data");
  endtask

  task automatic t_groups;  // R4: two shared words in one bank
    int seen;
    for (int l = 0; l < LANES; l++) bAddr[l] = (l < 8) ? 8'd5 : 8'd21;
    runReq(1'b0, '1, seen);
    checkCost(seen, 2, "R4 grouped share cost");
    checkRead('1, "R4 grouped data");
  endtask

  task automatic t_masked;  // R6
    int seen;
    for (int l = 0; l < LANES; l++) bAddr[l] = AW'(8 * l);
    runReq(1'b0, 16'h00FF, seen);
    checkCost(seen, 4, "R6 masked cost");
    checkRead(16'h00FF, "R6 masked data");
  endtask

  task automatic t_writeWinner;  // R5, R6
    int seen;
    for (int l = 0; l < LANES; l++) begin
      bAddr[l] = 8'd100;
      bData[l] = 32'hC0DE_0000 + l;
    end
    bAddr[1] = 8'd101;
    runReq(1'b1, 16'h0228, seen);  // lanes 3, 5, 9
    checkCost(seen, 1, "R5 same word write cost");
    for (int l = 0; l < LANES; l++) bAddr[l] = (l == 1) ? 8'd101 : 8'd100;
    runReq(1'b0, '1, seen);
    check(laneRdata[0 +: DW] == 32'hC0DE_0003, "R5 lowest lane wins",
          laneRdata[0 +: DW], 32'hC0DE_0003);
    check(laneRdata[1*DW +: DW] == model[101], "R6 idle lane wrote nothing",
          laneRdata[1*DW +: DW], model[101]);
  endtask

  task automatic t_empty;  // R9
    int seen;
    runReq(1'b0, '0, seen);
    checkCost(seen, 1, "R9 empty mask cost");
    check(laneValid == '0, "R9 empty laneValid", laneValid, 0);
  endtask

  task automatic t_deepWrite;  // R3 on writes
    int seen;
    for (int l = 0; l < LANES; l++) begin
      bAddr[l] = AW'(BANKS * l + 2);
      bData[l] = 32'h7700_0000 ^ (l * 32'h0101);
    end
    runReq(1'b1, '1, seen);
    checkCost(seen, 16, "R3 write conflict cost");
    t_stride(2, BANKS, 16, "R3 deep read cost");
  endtask

  task automatic t_busyDrop;  // R7
    int wd;
    for (int l = 0; l < LANES; l++) bAddr[l] = AW'(8 * l);
    @(negedge clk);
    drive(1'b0, '1);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(stall, "R7 stall after accept", stall, 1);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      bAddr[l] = 8'd0;
      bData[l] = 32'hDEAD_BEEF;
    end
    drive(1'b1, '1);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    wd = 0;
    while (!respValid && wd < 100) begin
      @(negedge clk);
      wd++;
    end
    check(respValid && !stall, "R7 stall low at completion", stall, 0);
    check(cycleCount == CNT_W'(8), "R7 first request cost", cycleCount, 8);
    @(negedge clk);
    check(!respValid, "R8 respValid single pulse", respValid, 0);
    check(!stall, "R7 dropped request not started", stall, 0);
    t_stride(0, 1, 1, "R7 storage untouched");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin
      bAddr[l] = '0;
      bData[l] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_fill();
    t_stride(48, 1, 1, "R2 unit stride cost");
    t_stride(0, 2, 2, "R3 stride two cost");
    t_stride(0, 8, 8, "R3 stride eight cost");
    t_broadcast();
    t_groups();
    t_masked();
    t_writeWinner();
    t_empty();
    t_deepWrite();
    t_busyDrop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule